// File: doc/BRIEF.md
# Parallel EEPROM Write Capture and Page Timer

This block is the device-side control logic of a byte-wide parallel EEPROM array, written as a synchronous model. Its bus inputs are sampled on the system clock: active-low chip select, write enable and output enable, an address bus and a data-in bus. From these it decodes the bus mode. It records the address and data of each write pulse into a page buffer.

A retriggerable window timer keeps the page open while write pulses keep arriving. Once the window runs out without a new pulse, the block raises a busy flag for a fixed number of clocks, which stands for the internal programming time. While busy, the block refuses new writes. A read during this time returns a polling status in place of data, so that software can detect the end of the write.

The captured page is presented on output ports for the array model that follows the block. That array model, analog programming and high-voltage behaviour are not part of this block.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: `mode` reports the decoded bus mode as follows. 0 = standby when `cs_n` is high. With `cs_n` low: 1 = read (`oe_n` low, `we_n` high), 2 = write (`oe_n` high, `we_n` low), 3 = output disabled (`oe_n` high, `we_n` high), 4 = write inhibited (`oe_n` low, `we_n` low).
- R2: `dout_en` is high only in read mode. Whenever `dout_en` is low, `dout` is zero.
- R3: A write pulse is every run of cycles in which `cs_n` and `we_n` are both low, `oe_n` is high and `busy` is low. The address is taken in the first cycle of the pulse, which is the later of the two falling edges. Address changes later in the pulse have no effect.
- R4: The data is taken from the last cycle of the pulse, which is the earlier of the two rising edges. The cycle after `cs_n` or `we_n` rises, the byte appears in slot `addr[PAGE_W-1:0]` of `page_data` (slot i at bits i*DATA_W upward) and `page_valid[i]` is set. `page_base` holds the upper address bits of the first byte of the page.
- R5: With `oe_n` low, no byte is captured. A pulse that ends because `oe_n` falls while `cs_n` and `we_n` stay low is dropped.
- R6: Every pulse cycle restarts the page window. If cycle k is the last pulse cycle, `busy` rises in cycle k+WIN_CYC+1. A pulse held low longer than the window does not raise `busy`.
- R7: `busy` stays high for exactly BUSY_CYC cycles. In the first cycle after `busy` falls, `page_valid` is all zero.
- R8: While `busy` is high, write pulses change neither the page buffer nor the window, so `busy` does not rise again afterwards.
- R9: A read while `busy` is high returns the complement of the most significant bit of the last byte written in the most significant bit of `dout`, and zero in all other bits.
- R10: A read while `busy` is low returns the contents of slot `addr[PAGE_W-1:0]` of the page buffer.
- R11: After reset, `busy`, `page_valid`, `page_data` and `page_base` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Read data or polling status |
| dout_en | output | 1 | High when the block drives read data |
| mode | output | 3 | Decoded bus mode (R1 encoding) |
| busy | output | 1 | Internal program time in progress |
| page_base | output | ADDR_W-PAGE_W | Upper address bits of the open page |
| page_valid | output | 2**PAGE_W | One bit per captured slot |
| page_data | output | (2**PAGE_W)*DATA_W | Captured bytes, slot i at bits i*DATA_W upward |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=3, WIN_CYC=20 and BUSY_CYC=30. At these values a whole page window and a whole programming period both complete in a few dozen cycles, so a single run covers the following cases:
- several pages,
- a write attempt in the middle of busy,
- polling reads on both values of the status bit,
- a pulse held low longer than the window.

The 8-slot page lets one page hold bytes at non-adjacent slots. It also lets an address change in the middle of a pulse point at a distinct slot that must stay untouched.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_OUTDIS  = 3'd3,
    MODE_INHIBIT = 3'd4
  } bus_mode_e;

  function automatic bus_mode_e decode_mode(input logic cs_n, input logic we_n, input logic oe_n);
    bus_mode_e m;
    if (cs_n)                m = MODE_STANDBY;
    else if (!oe_n && we_n)  m = MODE_READ;
    else if (oe_n && !we_n)  m = MODE_WRITE;
    else if (oe_n && we_n)   m = MODE_OUTDIS;
    else                     m = MODE_INHIBIT;
    return m;
  endfunction

endpackage

// File: rtl/epc_rst_sync.sv
module epc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] shift_q;
  logic [1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[1];

endmodule

// File: rtl/epc_bus_decode.sv
module epc_bus_decode #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic                   busy_i,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      din,
  output epc_pkg::bus_mode_e     mode_o,
  output logic                   pulse_o,
  output logic                   commit_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [DATA_W-1:0]      wr_data_o
);

  import epc_pkg::*;

  logic              act_q, act_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_en, data_en;
  logic              pulse_start;

  // mode decode and pulse tracking
  always_comb begin
    mode_o      = decode_mode(cs_n, we_n, oe_n);
    pulse_o     = (mode_o == MODE_WRITE) && !busy_i;
    pulse_start = pulse_o && !act_q;
    // pulse ends on the first of cs_n / we_n rising; an oe_n abort commits nothing
    commit_o    = act_q && (cs_n || we_n);
    act_d       = pulse_o;
    addr_en     = pulse_start;
    data_en     = pulse_o;
    addr_d      = addr;
    data_d      = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act_d;
      if (addr_en) addr_q <= addr_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  // R3: the held address does not move after the first pulse cycle
  a_r3_addr_held_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && pulse_o) |=> $stable(addr_q));

  // R5: a pulse cut short by oe_n leaves no commit behind
  a_r5_oe_abort_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !oe_n && !cs_n && !we_n) |-> !commit_o);

endmodule

// File: rtl/epc_page_timer.sv
module epc_page_timer #(
  parameter int unsigned WIN_CYC  = 37500,
  parameter int unsigned BUSY_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic busy_o,
  output logic busy_end_o
);

  localparam int unsigned WIN_W  = $clog2(WIN_CYC + 1);
  localparam int unsigned BUSY_W = $clog2(BUSY_CYC + 1);

  logic [WIN_W-1:0]  win_q, win_d;
  logic [BUSY_W-1:0] prog_q, prog_d;
  logic              expire;

  always_comb begin
    win_d  = win_q;
    expire = 1'b0;
    if (pulse_i) begin
      win_d = WIN_W'(WIN_CYC);
    end else if (win_q != '0) begin
      win_d  = win_q - WIN_W'(1);
      expire = (win_q == WIN_W'(1));
    end

    prog_d = prog_q;
    if (expire)              prog_d = BUSY_W'(BUSY_CYC);
    else if (prog_q != '0)   prog_d = prog_q - BUSY_W'(1);

    busy_o     = (prog_q != '0);
    busy_end_o = (prog_q == BUSY_W'(1)) && !expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      prog_q <= '0;
    end else begin
      win_q  <= win_d;
      prog_q <= prog_d;
    end
  end

  // R6: a pulse cycle is never followed directly by busy
  a_r6_no_busy_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> !busy_o);

  // R8: no pulse is accepted while programming
  a_r8_no_pulse_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pulse_i);

endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_i,
  input  logic                          clear_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [ADDR_W-PAGE_W-1:0]      base_o,
  output logic [(1<<PAGE_W)-1:0]        valid_o,
  output logic [(1<<PAGE_W)*DATA_W-1:0] data_o,
  output logic [DATA_W-1:0]             last_o
);

  localparam int unsigned PAGE_N = 1 << PAGE_W;
  localparam int unsigned BASE_W = ADDR_W - PAGE_W;

  logic [PAGE_N-1:0] valid_q, valid_d, slot_sel;
  logic [BASE_W-1:0] base_q;
  logic [DATA_W-1:0] last_q;
  logic              base_en;

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              byte_en;
    always_comb begin
      slot_sel[g] = (wr_addr_i[PAGE_W-1:0] == PAGE_W'(g));
      byte_en     = commit_i && slot_sel[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= wr_data_i;
    end
    assign data_o[g*DATA_W +: DATA_W] = byte_q;
  end

  always_comb begin
    valid_d = valid_q;
    if (clear_i)       valid_d = '0;
    else if (commit_i) valid_d = valid_q | slot_sel;
    base_en = commit_i && (valid_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      base_q  <= '0;
      last_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (base_en)  base_q <= wr_addr_i[ADDR_W-1:PAGE_W];
      if (commit_i) last_q <= wr_data_i;
    end
  end

  assign base_o  = base_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;

  // R4: each commit adds exactly one valid slot or keeps an already valid one
  a_r4_one_slot_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !clear_i) |=> ($countones(valid_q & ~$past(valid_q)) <= 1) && (valid_q != '0));

endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 6,
  parameter int unsigned WIN_CYC  = 37500,
  parameter int unsigned BUSY_CYC = 2500000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          we_n,
  input  logic                          oe_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             din,
  output logic [DATA_W-1:0]             dout,
  output logic                          dout_en,
  output logic [2:0]                    mode,
  output logic                          busy,
  output logic [ADDR_W-PAGE_W-1:0]      page_base,
  output logic [(1<<PAGE_W)-1:0]        page_valid,
  output logic [(1<<PAGE_W)*DATA_W-1:0] page_data
);

  import epc_pkg::*;

  localparam int unsigned PAGE_N = 1 << PAGE_W;

  logic              rst_int_n;
  bus_mode_e         mode_w;
  logic              pulse_w, commit_w, busy_end_w;
  logic [ADDR_W-1:0] wr_addr_w;
  logic [DATA_W-1:0] wr_data_w, last_w, slot_rd;
  logic [PAGE_W-1:0] rd_idx;

  epc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  epc_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .busy_i    (busy),
    .addr      (addr),
    .din       (din),
    .mode_o    (mode_w),
    .pulse_o   (pulse_w),
    .commit_o  (commit_w),
    .wr_addr_o (wr_addr_w),
    .wr_data_o (wr_data_w)
  );

  epc_page_timer #(.WIN_CYC(WIN_CYC), .BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pulse_i    (pulse_w),
    .busy_o     (busy),
    .busy_end_o (busy_end_w)
  );

  epc_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .commit_i  (commit_w),
    .clear_i   (busy_end_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (wr_data_w),
    .base_o    (page_base),
    .valid_o   (page_valid),
    .data_o    (page_data),
    .last_o    (last_w)
  );

  // read path: polling status while busy, page slot otherwise
  always_comb begin
    rd_idx  = addr[PAGE_W-1:0];
    slot_rd = page_data[rd_idx*DATA_W +: DATA_W];
    mode    = mode_w;
    dout_en = (mode_w == MODE_READ);
    dout    = '0;
    if (dout_en) begin
      if (busy) dout = {~last_w[DATA_W-1], {(DATA_W-1){1'b0}}};
      else      dout = slot_rd;
    end
  end

  // R2: no data driven while a write is being presented
  a_r2_quiet_in_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cs_n && !we_n) |-> (!dout_en && dout == '0));

  // R7: valid slots are gone when busy drops
  a_r7_valid_cleared: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> (page_valid == '0));

  // R8: page contents frozen while programming
  a_r8_page_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> $stable(page_data));

  // R9: polling status carries a single meaningful bit
  a_r9_poll_low_bits: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && dout_en) |-> (dout[DATA_W-2:0] == '0));

  // R1: inhibit mode never yields a pulse, so no byte follows it
  a_r1_inhibit_no_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_w == MODE_INHIBIT) |-> !pulse_w);

  if (PAGE_N < 2) begin : g_bad_page
    initial $error("PAGE_W must be at least 1");
  end

endmodule

// File: tb/eeprom_page_ctrl_tb_top.sv
module eeprom_page_ctrl_tb_top;

  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int PW   = 3;
  localparam int PN   = 1 << PW;
  localparam int WIN  = 20;
  localparam int BUSY = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy;
  logic [2:0] mode;
  logic [AW-PW-1:0] page_base;
  logic [PN-1:0] page_valid;
  logic [PN*DW-1:0] page_data;

  always #2 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WIN_CYC(WIN), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .mode(mode),
    .busy(busy), .page_base(page_base), .page_valid(page_valid), .page_data(page_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  task automatic chk(input string req, input string what, input logic [63:0] actv, input logic [63:0] expv);
    checks++;
    if (actv !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  // behavioural reference model
  int rs_cnt = 0;
  int m_since = -1;
  int m_busy_left = 0;
  bit m_act_q = 0;
  bit m_act, m_commit;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data, m_last;
  logic [DW-1:0] m_mem [PN];
  logic [PN-1:0] m_valid;
  logic [AW-PW-1:0] m_base;

  task automatic m_reset();
    m_since = -1; m_busy_left = 0; m_act_q = 0;
    m_addr = '0; m_data = '0; m_last = '0; m_valid = '0; m_base = '0;
    foreach (m_mem[i]) m_mem[i] = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rs_cnt = 0; m_reset();
    end else if (rs_cnt < 2) begin
      rs_cnt++; m_reset();
    end else begin
      m_act = !cs_n && !we_n && oe_n && (m_busy_left == 0);
      m_commit = m_act_q && (cs_n || we_n);
      if (m_commit) begin
        if (m_valid == '0) m_base = m_addr[AW-1:PW];
        m_mem[m_addr % PN] = m_data;
        m_valid[m_addr % PN] = 1'b1;
        m_last = m_data;
      end
      if (m_act && !m_act_q) m_addr = addr;
      if (m_act) m_data = din;
      if (m_busy_left > 0) begin
        m_busy_left--;
        if (m_busy_left == 0) m_valid = '0;
      end
      if (m_act) m_since = 0;
      else if (m_since >= 0) begin
        m_since++;
        if (m_since == WIN) begin m_busy_left = BUSY; m_since = -1; end
      end
      m_act_q = m_act;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [2:0] e_mode;
      logic e_en, e_busy;
      logic [DW-1:0] e_dout;
      logic [PN*DW-1:0] e_data;
      e_busy = (m_busy_left > 0);
      if (cs_n) e_mode = 3'd0;
      else if (!oe_n && we_n) e_mode = 3'd1;
      else if (oe_n && !we_n) e_mode = 3'd2;
      else if (oe_n && we_n) e_mode = 3'd3;
      else e_mode = 3'd4;
      e_en = (e_mode == 3'd1);
      e_dout = '0;
      if (e_en) e_dout = e_busy ? {~m_last[DW-1], 7'h00} : m_mem[addr % PN];
      for (int i = 0; i < PN; i++) e_data[i*DW +: DW] = m_mem[i];
      chk("R1", "mode", 64'(mode), 64'(e_mode));
      chk("R2", "dout_en", 64'(dout_en), 64'(e_en));
      chk(e_busy ? "R9" : "R10", "dout", 64'(dout), 64'(e_dout));
      chk("R6", "busy", 64'(busy), 64'(e_busy));
      chk("R7", "page_valid", 64'(page_valid), 64'(m_valid));
      chk("R4", "page_data", 64'(page_data), 64'(e_data));
      chk("R4", "page_base", 64'(page_base), 64'(m_base));
    end
  end

  task automatic step(input logic c, input logic w, input logic o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog run did not end actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    hold(3);
    #1 rst_n = 1'b1;
    hold(3);
    cmp_on = 1;
    // R11: reset state
    @(negedge clk);
    chk("R11", "busy", 64'(busy), 64'd0);
    chk("R11", "page_valid", 64'(page_valid), 64'd0);
    chk("R11", "page_data", 64'(page_data), 64'd0);
    chk("R11", "page_base", 64'(page_base), 64'd0);

    // we_n-controlled byte to slot 2
    step(0, 1, 1, 8'h12, 8'h00);
    step(0, 0, 1, 8'h12, 8'hA5);
    step(0, 0, 1, 8'h12, 8'hA5);
    step(0, 1, 1, 8'h12, 8'h11);
    step(1, 1, 1, 8'h12, 8'h00);
    // second byte to slot 5
    step(0, 0, 1, 8'h15, 8'h3C);
    step(1, 1, 1, 8'h15, 8'hFF);
    // cs_n-controlled byte, address moved mid-pulse (R3)
    step(1, 0, 1, 8'h13, 8'h00);
    step(0, 0, 1, 8'h13, 8'h5A);
    step(0, 0, 1, 8'h77, 8'h6E);
    step(1, 0, 1, 8'h77, 8'h00);
    step(1, 1, 1, 8'h00, 8'h00);
    @(negedge clk);
    chk("R3", "slot3", 64'(page_data[3*DW +: DW]), 64'h6E);
    chk("R3", "slot7 untouched", 64'(page_data[7*DW +: DW]), 64'h00);
    chk("R4", "base", 64'(page_base), 64'h02);
    chk("R4", "valid", 64'(page_valid), 64'h2C);
    step(0, 1, 0, 8'h13, 8'h00);
    @(negedge clk);
    chk("R10", "read slot3", 64'(dout), 64'h6E);
    step(1, 1, 1, 8'h00, 8'h00);
    hold(25);
    chk("R6", "busy after window", 64'(busy), 64'd1);
    step(0, 1, 0, 8'h12, 8'h00);
    @(negedge clk);
    chk("R9", "poll status", 64'(dout), 64'h80);
    // write attempt while busy (R8)
    step(0, 0, 1, 8'h14, 8'h99);
    step(1, 1, 1, 8'h00, 8'h00);
    @(negedge clk);
    chk("R8", "slot4 untouched", 64'(page_data[4*DW +: DW]), 64'h00);
    chk("R8", "valid unchanged", 64'(page_valid), 64'h2C);
    hold(40);
    chk("R7", "busy done", 64'(busy), 64'd0);
    chk("R7", "valid cleared", 64'(page_valid), 64'h00);
    hold(25);
    chk("R8", "no restart", 64'(busy), 64'd0);
    step(0, 1, 0, 8'h13, 8'h00);
    @(negedge clk);
    chk("R10", "true data after busy", 64'(dout), 64'h6E);

    // inhibited write (R5)
    step(0, 0, 0, 8'h16, 8'h42);
    hold(2);
    step(1, 1, 1, 8'h00, 8'h00);
    hold(25);
    chk("R5", "inhibit no byte", 64'(page_valid), 64'h00);
    chk("R5", "inhibit no busy", 64'(busy), 64'd0);
    // pulse aborted by oe_n
    step(0, 0, 1, 8'h16, 8'h42);
    step(0, 0, 0, 8'h16, 8'h42);
    step(1, 1, 1, 8'h00, 8'h00);
    hold(3);
    chk("R5", "aborted pulse dropped", 64'(page_valid), 64'h00);
    hold(60);

    // pulse longer than the window (R6)
    step(0, 0, 1, 8'h08, 8'hC3);
    hold(30);
    chk("R6", "long pulse no busy", 64'(busy), 64'd0);
    step(1, 1, 1, 8'h00, 8'h00);
    @(negedge clk);
    chk("R4", "long pulse byte", 64'(page_valid), 64'h01);
    chk("R4", "long pulse base", 64'(page_base), 64'h01);
    hold(21);
    step(0, 1, 0, 8'h08, 8'h00);
    @(negedge clk);
    chk("R6", "busy after long pulse", 64'(busy), 64'd1);
    chk("R9", "poll bit clear", 64'(dout), 64'h00);
    step(1, 1, 1, 8'h00, 8'h00);
    hold(40);
    finish_run();
  end

endmodule